// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a watchdog peripheral for a system that must recover from hung software. A free-running prescaler produces a tick. Two countdown stages run on that tick, one after the other. When the first stage runs out, an interrupt can be raised to warn software. If software still does not service the watchdog, the second stage runs out. The block then drives a reset request and sets a sticky flag, so software can see after the restart that the watchdog caused it.

Software loads both stage lengths and services the watchdog through a simple register port. Writes to the two preload registers and to the service register are guarded. Software must first write the value 0x80 and then 0x86 to the service register. After that, exactly one guarded write is taken, and the guard closes again. A control register holds the run, function and lock bits. Once lock is set, the watchdog cannot be stopped until the next reset. A configuration register selects the tick rate, whether the first stage raises the interrupt, and whether the reset request reaches the output.

Register offsets: stage-1 preload 0x00, stage-2 preload 0x04, interrupt status 0x08, service 0x0C, control 0x10, configuration 0x14. Reads are combinational and return zero when `rdEn` is low or the address is unmapped.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, `irqOut` and `rstOut` are low. Both preloads read 0x3C00. Interrupt status, the service register, control and configuration all read 0.
- R2: Writing 0x0080 and then 0x0086 (low 16 bits, masked by byte strobes) to offset 0x0C opens the guard. Exactly one following write to 0x00, 0x04 or 0x0C is accepted, and the guard then closes by itself.
- R3: A guarded write while the guard is closed has no effect. At offset 0x0C, a value other than 0x0080 while idle leaves the guard closed, and a second value other than 0x0086 returns it to idle.
- R4: Each preload holds 20 bits. Bits 31:20 of a write are ignored. Only bytes whose strobe is set are updated.
- R5: An accepted write to offset 0x0C with bit 8 set reloads stage 1 from its preload, restarts the prescaler and clears a pending reset request. Stage-1 expiry is then due 2^k·(P1+1) cycles after that write.
- R6: The tick comes once every 2^15 clock cycles when configuration bit 2 is 0, and once every 2^5 cycles when it is 1. A stage with preload P lasts P+1 ticks. Stage 1 of a run started by the enable write ends 2^k·(P1+1) cycles after that write.
- R7: When stage 1 ends, status bit 0 at 0x08 sets and `irqOut` rises, unless configuration bits 1:0 are 11. Stage 2 then starts from its preload.
- R8: In watchdog function, the end of stage 2 comes 2^k·(P1+P2+2) cycles after the start. It sets the timeout flag (bit 9 at 0x0C), stops the countdown, and raises `rstOut` unless configuration bit 5 is 1.
- R9: The timeout flag stays set until an accepted guarded write of 1 to bit 9 at 0x0C. Status bit 0 clears on an unguarded write of 1 to bit 0 at 0x08, and `irqOut` falls with it.
- R10: In the control register at 0x10, bit 0 is lock, bit 1 is enable and bit 2 is function (0 for watchdog, 1 for plain timer). While lock is 1, enable cannot be cleared. Lock clears only on reset.
- R11: While enable is 0, the counters hold their preloads, the prescaler holds at zero, and `rstOut` is low.
- R12: In plain-timer function, each stage-1 expiry raises the interrupt and restarts stage 1. Stage 2 never runs, and neither `rstOut` nor the timeout flag is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Write byte address |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Write byte strobes |
| rdEn | input | 1 | Read request |
| rdAddr | input | 5 | Read byte address |
| rdData | output | 32 | Read data, combinational |
| irqOut | output | 1 | Stage-1 expiry interrupt |
| rstOut | output | 1 | Reset request on stage-2 expiry |

## Verification
Register writes take effect at the clock edge on which they are presented, and read data is combinational, so each register is read back in the cycle after its write. Stage expiries are registered on the edge that consumes the final tick. This puts the interrupt exactly 2^k·(P1+1) edges and the reset request 2^k·(P1+P2+2) edges after the enabling or reloading write. The bench counts edges, checks each output one edge before its due edge and again on that edge, and sweeps both preloads over 0 to 3 with the fast tick. A disable drops `rstOut` in the same cycle because the output is gated by enable. A cleared interrupt is low on the edge of the clearing write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_PRE1   = 5'h00;
  localparam logic [ADDR_W-1:0] ADR_PRE2   = 5'h04;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 5'h08;
  localparam logic [ADDR_W-1:0] ADR_SVC    = 5'h0C;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 5'h10;
  localparam logic [ADDR_W-1:0] ADR_CFG    = 5'h14;

  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  typedef enum logic [1:0] {UL_IDLE, UL_ARMED, UL_OPEN} ul_state_t;

  // strobes from the register block to the counting datapath
  typedef struct packed {
    logic reload;
    logic clrTimeout;
    logic clrIrq;
  } strobe_t;

  // static mode levels for the datapath
  typedef struct packed {
    logic enable;
    logic timerMode;
    logic fastTick;
    logic irqEn;
    logic rstEn;
  } mode_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int              CNT_W       = 20,
  parameter logic [CNT_W-1:0] RST_PRELOAD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrStrb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              irqPend,
  input  logic              timeoutFlag,
  output logic [CNT_W-1:0]  pre1,
  output logic [CNT_W-1:0]  pre2,
  output mode_t             mode,
  output strobe_t           stb
);
  localparam int PAD_W = 32 - CNT_W;

  logic [31:0] byteMask, wdEff;
  logic [CNT_W-1:0] pre1Q, pre2Q;
  logic lockQ, enableQ, funcQ, fastQ, rstDisQ;
  logic [1:0] intTypeQ;
  ul_state_t ulState, ulNext;
  logic isSvcWr, isPre1Wr, isPre2Wr, isOpen;
  logic unusedBits;

  always_comb begin
    for (int b = 0; b < 4; b++) byteMask[b*8 +: 8] = {8{wrStrb[b]}};
  end
  assign wdEff      = wrData & byteMask;
  assign unusedBits = ^wdEff[31:CNT_W];

  assign isSvcWr  = wrEn && (wrAddr == ADR_SVC);
  assign isPre1Wr = wrEn && (wrAddr == ADR_PRE1);
  assign isPre2Wr = wrEn && (wrAddr == ADR_PRE2);
  assign isOpen   = (ulState == UL_OPEN);

  // unlock sequencer
  always_comb begin
    ulNext = ulState;
    unique case (ulState)
      UL_IDLE:  if (isSvcWr && wdEff[15:0] == KEY_FIRST) ulNext = UL_ARMED;
      UL_ARMED: if (isSvcWr) ulNext = (wdEff[15:0] == KEY_SECOND) ? UL_OPEN : UL_IDLE;
      UL_OPEN:  if (isSvcWr || isPre1Wr || isPre2Wr) ulNext = UL_IDLE;
      default:  ulNext = UL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ulState  <= UL_IDLE;
      pre1Q    <= RST_PRELOAD;
      pre2Q    <= RST_PRELOAD;
      lockQ    <= 1'b0;
      enableQ  <= 1'b0;
      funcQ    <= 1'b0;
      fastQ    <= 1'b0;
      rstDisQ  <= 1'b0;
      intTypeQ <= 2'b00;
    end else begin
      ulState <= ulNext;
      if (isOpen && isPre1Wr) pre1Q <= (pre1Q & ~byteMask[CNT_W-1:0]) | wdEff[CNT_W-1:0];
      if (isOpen && isPre2Wr) pre2Q <= (pre2Q & ~byteMask[CNT_W-1:0]) | wdEff[CNT_W-1:0];
      if (wrEn && wrAddr == ADR_CTRL && wrStrb[0]) begin
        lockQ   <= lockQ | wdEff[0];
        enableQ <= wdEff[1] | (lockQ & enableQ);
        funcQ   <= wdEff[2];
      end
      if (wrEn && wrAddr == ADR_CFG && wrStrb[0]) begin
        intTypeQ <= wdEff[1:0];
        fastQ    <= wdEff[2];
        rstDisQ  <= wdEff[5];
      end
    end
  end

  always_comb begin
    stb.reload     = isOpen && isSvcWr && wdEff[8];
    stb.clrTimeout = isOpen && isSvcWr && wdEff[9];
    stb.clrIrq     = wrEn && (wrAddr == ADR_STAT) && wrStrb[0] && wdEff[0];
  end

  assign pre1 = pre1Q;
  assign pre2 = pre2Q;
  always_comb begin
    mode.enable    = enableQ;
    mode.timerMode = funcQ;
    mode.fastTick  = fastQ;
    mode.irqEn     = (intTypeQ != 2'b11);
    mode.rstEn     = !rstDisQ;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (rdAddr)
        ADR_PRE1: rdData = {{PAD_W{1'b0}}, pre1Q};
        ADR_PRE2: rdData = {{PAD_W{1'b0}}, pre2Q};
        ADR_STAT: rdData = {31'b0, irqPend};
        ADR_SVC:  rdData = {22'b0, timeoutFlag, 9'b0};
        ADR_CTRL: rdData = {29'b0, funcQ, enableQ, lockQ};
        ADR_CFG:  rdData = {26'b0, rstDisQ, 2'b00, fastQ, intTypeQ};
        default:  rdData = '0;
      endcase
    end
  end

  // R2
  preload_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ulState != UL_OPEN) |=> ($stable(pre1Q) && $stable(pre2Q)));
  // R2
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && (isSvcWr || isPre1Wr || isPre2Wr)) |=> (ulState == UL_IDLE));
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && enableQ) |=> enableQ);
  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  input  mode_t            mode,
  input  strobe_t          stb,
  output logic             irqPend,
  output logic             timeoutFlag,
  output logic             rstReq
);
  logic [SLOW_LOG2-1:0] divQ;
  logic [CNT_W-1:0]     cntQ;
  logic stage2Q, expiredQ, irqPendQ, timeoutQ;
  logic tick, live, atZero, stage1Done, stage2Done;

  assign tick       = mode.enable && (mode.fastTick ? (&divQ[FAST_LOG2-1:0]) : (&divQ));
  assign live       = tick && !expiredQ && !stb.reload;
  assign atZero     = (cntQ == '0);
  assign stage1Done = live && atZero && !stage2Q;
  assign stage2Done = live && atZero && stage2Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ     <= '0;
      cntQ     <= '0;
      stage2Q  <= 1'b0;
      expiredQ <= 1'b0;
    end else if (!mode.enable || stb.reload) begin
      divQ     <= '0;
      cntQ     <= pre1;
      stage2Q  <= 1'b0;
      expiredQ <= 1'b0;
    end else begin
      divQ <= divQ + 1'b1;
      if (live) begin
        if (!atZero) begin
          cntQ <= cntQ - 1'b1;
        end else if (stage2Done) begin
          expiredQ <= 1'b1;
        end else if (mode.timerMode) begin
          cntQ <= pre1;
        end else begin
          stage2Q <= 1'b1;
          cntQ    <= pre2;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPendQ <= 1'b0;
      timeoutQ <= 1'b0;
    end else begin
      irqPendQ <= (irqPendQ & !stb.clrIrq) | (stage1Done & mode.irqEn);
      timeoutQ <= (timeoutQ & !stb.clrTimeout) | stage2Done;
    end
  end

  assign irqPend     = irqPendQ;
  assign timeoutFlag = timeoutQ;
  assign rstReq      = expiredQ && mode.enable && mode.rstEn;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mode.enable |=> (!expiredQ && !stage2Q && divQ == '0));
  // R8
  flag_with_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutQ) |-> expiredQ);
  // R12
  timer_no_stage2_chk: assert property (@(posedge clk) disable iff (!rstN)
    mode.timerMode |=> !$rose(stage2Q));
  // R8
  expired_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expiredQ && mode.enable && !stb.reload) |=> ($stable(cntQ) && expiredQ));
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int              CNT_W       = 20,
  parameter int              SLOW_LOG2   = 15,
  parameter int              FAST_LOG2   = 5,
  parameter logic [CNT_W-1:0] RST_PRELOAD = 20'h03C00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [3:0]  wrStrb,
  input  logic        rdEn,
  input  logic [4:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irqOut,
  output logic        rstOut
);
  logic [CNT_W-1:0] pre1, pre2;
  mode_t   mode;
  strobe_t stb;
  logic    irqPend, timeoutFlag;

  wdog_regs #(.CNT_W(CNT_W), .RST_PRELOAD(RST_PRELOAD)) regsI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrb(wrStrb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .irqPend(irqPend), .timeoutFlag(timeoutFlag),
    .pre1(pre1), .pre2(pre2), .mode(mode), .stb(stb)
  );

  wdog_core #(.CNT_W(CNT_W), .SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) coreI (
    .clk(clk), .rstN(rstN), .pre1(pre1), .pre2(pre2), .mode(mode), .stb(stb),
    .irqPend(irqPend), .timeoutFlag(timeoutFlag), .rstReq(rstOut)
  );

  assign irqOut = irqPend;
endmodule

// File: tb/twostage_wdog_test.sv
module twostage_wdog_test;
  localparam logic [4:0] A_PRE1 = 5'h00, A_PRE2 = 5'h04, A_STAT = 5'h08,
                         A_SVC = 5'h0C, A_CTRL = 5'h10, A_CFG = 5'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [4:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [3:0] wrStrb = '0;
  logic irqOut, rstOut;
  int checks = 0, fails = 0, cyc = 0;
  logic done = 1'b0;

  twostage_wdog uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrStrb(wrStrb), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .irqOut(irqOut), .rstOut(rstOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrStrb = s;
    @(negedge clk);
    wrEn = 1'b0; wrStrb = '0;
  endtask

  task automatic unlock();
    wr(A_SVC, 32'h80, 4'h3);
    wr(A_SVC, 32'h86, 4'h3);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rdEn = 1'b1; rdAddr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic atEdge(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic cleanup();
    logic [31:0] v;
    wr(A_STAT, 32'h1, 4'h1);
    chk("R9 irq cleared by status write", irqOut, 0);
    wr(A_CTRL, 32'h0, 4'h1);
    chk("R11 rstOut low once disabled", rstOut, 0);
    unlock();
    wr(A_SVC, 32'h200, 4'h3);
    rd(A_SVC, v);
    chk("R9 timeout flag cleared", v, 0);
  endtask

  task automatic setPre(input int p1, input int p2);
    unlock(); wr(A_PRE1, p1, 4'hF);
    unlock(); wr(A_PRE2, p2, 4'hF);
  endtask

  task automatic runWd(input int p1, input int p2, input logic [31:0] cfg,
                       input logic irqOn, input logic rstOn, input int shift);
    int e0, tIrq, tRst;
    logic [31:0] v;
    setPre(p1, p2);
    wr(A_CFG, cfg, 4'h1);
    wr(A_CTRL, 32'h2, 4'h1);
    e0   = cyc;
    tIrq = e0 + (p1 + 1) * (1 << shift);
    tRst = e0 + (p1 + p2 + 2) * (1 << shift);
    atEdge(tIrq - 1);
    chk("R6 irq low one edge before stage-1 end", irqOut, 0);
    atEdge(tIrq);
    chk("R7 irq at stage-1 end", irqOut, irqOn);
    rd(A_STAT, v);
    chk("R7 status bit0", v, irqOn);
    atEdge(tRst - 1);
    chk("R8 rst low one edge before stage-2 end", rstOut, 0);
    rd(A_SVC, v);
    chk("R8 flag clear before stage-2 end", v, 0);
    atEdge(tRst);
    chk("R8 rstOut at stage-2 end", rstOut, rstOn);
    rd(A_SVC, v);
    chk("R8 timeout flag set", v, 32'h200);
    wr(A_STAT, 32'h0, 4'h1);
    rd(A_SVC, v);
    chk("R9 timeout flag sticky", v, 32'h200);
    cleanup();
  endtask

  initial begin
    logic [31:0] v;
    int e0, r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut after reset", irqOut, 0);
    chk("R1 rstOut after reset", rstOut, 0);
    rd(A_PRE1, v); chk("R1 preload1 reset", v, 32'h3C00);
    rd(A_PRE2, v); chk("R1 preload2 reset", v, 32'h3C00);
    rd(A_STAT, v); chk("R1 status reset", v, 0);
    rd(A_SVC, v);  chk("R1 service reset", v, 0);
    rd(A_CTRL, v); chk("R1 control reset", v, 0);
    rd(A_CFG, v);  chk("R1 config reset", v, 0);

    // R3 guarded writes without unlock
    wr(A_PRE1, 32'h5, 4'hF);
    rd(A_PRE1, v); chk("R3 preload write ignored while locked", v, 32'h3C00);
    wr(A_SVC, 32'h80, 4'h3); wr(A_SVC, 32'h55, 4'h3); wr(A_SVC, 32'h86, 4'h3);
    wr(A_PRE1, 32'h7, 4'hF);
    rd(A_PRE1, v); chk("R3 wrong second key returns to idle", v, 32'h3C00);

    // R2 / R4
    unlock(); wr(A_PRE1, 32'hFFFF_FFFF, 4'hF);
    rd(A_PRE1, v); chk("R4 upper bits ignored", v, 32'hFFFFF);
    wr(A_PRE1, 32'h1, 4'hF);
    rd(A_PRE1, v); chk("R2 only one write per unlock", v, 32'hFFFFF);
    unlock(); wr(A_PRE1, 32'h0000_3412, 4'h1);
    rd(A_PRE1, v); chk("R4 byte strobe selects byte", v, 32'hFFF12);
    unlock(); wr(A_PRE2, 32'h0000_0009, 4'hF);
    rd(A_PRE2, v); chk("R2 preload2 accepted after unlock", v, 32'h9);

    // R6 R7 R8 sweep with fast tick
    for (int p1 = 0; p1 < 4; p1++)
      for (int p2 = 0; p2 < 4; p2++)
        runWd(p1, p2, 32'h04, 1'b1, 1'b1, 5);

    // R7 interrupt disabled, R8 reset output disabled
    runWd(1, 2, 32'h07, 1'b0, 1'b1, 5);
    runWd(2, 1, 32'h24, 1'b1, 1'b0, 5);

    // R6 slow tick
    runWd(0, 0, 32'h00, 1'b1, 1'b1, 15);

    // R5 reload restarts countdown
    setPre(3, 3);
    wr(A_CFG, 32'h04, 4'h1);
    wr(A_CTRL, 32'h2, 4'h1);
    e0 = cyc;
    atEdge(e0 + 10);
    unlock();
    wr(A_SVC, 32'h100, 4'h3);
    r0 = cyc;
    atEdge(r0 + 127); chk("R5 no irq before restarted stage-1 end", irqOut, 0);
    atEdge(r0 + 128); chk("R5 irq after restarted stage-1", irqOut, 1);
    atEdge(r0 + 256); chk("R5 rstOut after restarted stage-2", rstOut, 1);
    unlock();
    wr(A_SVC, 32'h100, 4'h3);
    chk("R5 reload clears reset request", rstOut, 0);
    rd(A_SVC, v); chk("R9 flag survives reload", v, 32'h200);
    cleanup();

    // R12 plain-timer function
    setPre(1, 0);
    wr(A_CTRL, 32'h6, 4'h1);
    e0 = cyc;
    atEdge(e0 + 63);  chk("R12 timer irq low before period", irqOut, 0);
    atEdge(e0 + 64);  chk("R12 timer irq first period", irqOut, 1);
    wr(A_STAT, 32'h1, 4'h1);
    atEdge(e0 + 127); chk("R12 timer irq cleared", irqOut, 0);
    atEdge(e0 + 128); chk("R12 timer irq second period", irqOut, 1);
    atEdge(e0 + 400); chk("R12 timer never resets", rstOut, 0);
    rd(A_SVC, v); chk("R12 timer never sets flag", v, 0);
    cleanup();

    // R11 held while disabled
    atEdge(cyc + 200);
    chk("R11 no irq while disabled", irqOut, 0);

    // R10 lock
    wr(A_CTRL, 32'h3, 4'h1);
    wr(A_CTRL, 32'h0, 4'h1);
    rd(A_CTRL, v); chk("R10 locked enable cannot clear", v, 32'h3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule